// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block is the receive half of an asynchronous serial port. A clock enable from a baud divider, running at sixteen times the bit rate, paces it. Once the line has rested at 1, a falling level marks a possible start bit. The receiver checks that level again half a bit later, then samples each following bit at its centre. Data bits arrive least significant first. An optional parity bit and one or two stop bits follow them. Each word that passes the acceptance checks goes into a 16-entry receive queue. Software or a bus bridge drains the queue through a show-ahead read port.

Four sticky status flags report queue fill, line errors, break and stale data. Each flag has its own interrupt enable, and all four share one interrupt output. A write-1-to-clear strobe clears the flags. A framing or parity error never stops the receiver: it is ready for the next frame at once. A frame whose first stop bit is 0 is discarded. While the break flag is set, no word is allowed into the queue.

Top module: `serialRxFifo`

## Requirements
- R1: After reset all four flags are 0, the fill count is 0, `rdValid` and `irqOut` are 0, and the first word received is the first word read.
- R2: A start is accepted only after the line has been seen at 1 while idle. A 0 that has returned to 1 by the half-bit re-check is a glitch and produces no word and no flag.
- R3: Data bits are taken least significant bit first, one at each bit centre. An accepted word appears on `rdData` at the head of the queue.
- R4: With parity enabled, `cfgParityOdd`=0 expects even parity and 1 expects odd parity over data plus parity bit. A mismatch sets flag bit 1 (error), but the word is still stored.
- R5: A first stop bit read as 0 sets flag bit 1 and discards the word. With `cfgTwoStop`=1, the second stop bit is received but never checked.
- R6: After a framing or parity error, the next frame is received and stored normally.
- R7: A frame that is 0 in every position up to and including the first stop bit sets flag bit 2 (break). While flag bit 2 is set, no word enters the queue.
- R8: The queue holds 16 words. A word that arrives while it is full is dropped and the stored words are kept. `rdEn` on an empty queue changes nothing.
- R9: Flag bit 0 (data full) sets when a store brings the fill count to `cfgTrigLevel` or above.
- R10: Flag bit 3 (data ready) sets when the fill count is above 0 and below `cfgTrigLevel`, and 576 sample ticks pass with no start, store or read.
- R11: A 1 in `flagClr` bit i clears flag i. Setting the flag in the same cycle wins over clearing it.
- R12: `irqOut` is 1 exactly when some flag bit and the `cfgIrqEn` bit in the same position are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sample tick at 16x the bit rate |
| rxdIn | input | 1 | Serial line, idle high |
| cfgParityEn | input | 1 | A parity bit follows the data |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| cfgTwoStop | input | 1 | Two stop bits per frame |
| cfgTrigLevel | input | 5 | Fill level that raises the data-full flag |
| cfgIrqEn | input | 4 | Interrupt enable for each flag bit |
| flagClr | input | 4 | Write-1-to-clear strobe for each flag bit |
| rdEn | input | 1 | Pop the head word |
| rdData | output | 8 | Head word of the queue |
| rdValid | output | 1 | Queue not empty |
| fillCount | output | 5 | Number of stored words |
| flags | output | 4 | {ready, break, error, full} |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench sweeps data words across all six framing configurations. A receiver that sampled at bit edges, or shifted most significant bit first, would return wrong words in that sweep. Frames that mix good parity with bad, and a good first stop bit with a bad second one, catch a receiver that checks the wrong stop bit, stalls after an error, or drops words that have bad parity. A false start, a break followed by a good frame, a seventeenth word into a full queue and a read from an empty queue test the guard conditions. The data-ready timeout is checked on both sides of its limit, so a timer that fires early or never fires is caught.

// File: rtl/serRxPkg.sv
package serRxPkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_e;

  typedef struct packed {
    logic startSeen;
    logic frameDone;
    logic stopBad;
    logic parityBad;
    logic allZero;
  } rxStrb_t;

  localparam int FLAG_FULL = 0;
  localparam int FLAG_ERR  = 1;
  localparam int FLAG_BRK  = 2;
  localparam int FLAG_RDY  = 3;
  localparam int FLAG_N    = 4;
endpackage

// File: rtl/rxCtrl.sv
module rxCtrl
  import serRxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              rxdIn,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  output rxStrb_t           strb,
  output logic [DATA_W-1:0] wordOut
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 4);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rxState_e          state;
  logic [1:0]        syncQ;
  logic              rxS, markSeen, zeroQ, stopQ, parBitQ;
  logic [CNT_W-1:0]  tickCnt;
  logic [BIT_W-1:0]  bitIdx, stop1Idx, lastIdx;
  logic [DATA_W-1:0] shiftQ;

  assign rxS      = syncQ[1];
  assign stop1Idx = BIT_W'(DATA_W) + BIT_W'(cfgParityEn);
  assign lastIdx  = stop1Idx + BIT_W'(cfgTwoStop);
  assign wordOut  = shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      state    <= RX_IDLE;
      markSeen <= 1'b0;
      tickCnt  <= '0;
      bitIdx   <= '0;
      shiftQ   <= '0;
      zeroQ    <= 1'b1;
      stopQ    <= 1'b1;
      parBitQ  <= 1'b0;
      strb     <= '0;
    end else begin
      syncQ <= {syncQ[0], rxdIn};
      strb  <= '0;
      if (sampleEn) begin
        case (state)
          RX_IDLE: begin
            if (rxS) markSeen <= 1'b1;
            else if (markSeen) begin
              state          <= RX_START;
              tickCnt        <= '0;
              markSeen       <= 1'b0;
              strb.startSeen <= 1'b1;
            end
          end
          RX_START: begin
            if (tickCnt == MID) begin
              tickCnt <= '0;
              if (rxS) state <= RX_IDLE;
              else begin
                state  <= RX_BITS;
                bitIdx <= '0;
                zeroQ  <= 1'b1;
              end
            end else tickCnt <= tickCnt + 1'b1;
          end
          RX_BITS: begin
            if (tickCnt == LAST) begin
              tickCnt <= '0;
              bitIdx  <= bitIdx + 1'b1;
              if (bitIdx < BIT_W'(DATA_W)) shiftQ <= {rxS, shiftQ[DATA_W-1:1]};
              else if (cfgParityEn && bitIdx == BIT_W'(DATA_W)) parBitQ <= rxS;
              if (bitIdx <= stop1Idx) zeroQ <= zeroQ & ~rxS;
              if (bitIdx == stop1Idx) stopQ <= rxS;
              if (bitIdx == lastIdx) begin
                state          <= RX_IDLE;
                strb.frameDone <= 1'b1;
                strb.stopBad   <= (bitIdx == stop1Idx) ? ~rxS : ~stopQ;
                strb.allZero   <= (bitIdx == stop1Idx) ? (zeroQ & ~rxS) : zeroQ;
                strb.parityBad <= cfgParityEn && ((^shiftQ ^ parBitQ) != cfgParityOdd);
              end
            end else tickCnt <= tickCnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R2
  start_then_check_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startSeen |-> state == RX_START);

  // R3
  frame_from_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone |-> $past(state) == RX_BITS && $past(sampleEn));
endmodule

// File: rtl/rxData.sv
module rxData
  import serRxPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 16,
  parameter int TOUT_TICKS = 576
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleEn,
  input  rxStrb_t                      strb,
  input  logic [DATA_W-1:0]            wordIn,
  input  logic [$clog2(DEPTH):0]       cfgTrig,
  input  logic [FLAG_N-1:0]            flagClr,
  input  logic                         rdEn,
  output logic [DATA_W-1:0]            rdData,
  output logic                         rdValid,
  output logic [$clog2(DEPTH):0]       fillCount,
  output logic [FLAG_N-1:0]            flags
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int TW    = $clog2(TOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] FULL_N = CNT_W'(DEPTH);
  localparam logic [TW-1:0]    TOUT   = TW'(TOUT_TICKS);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  newCount;
  logic [TW-1:0]     toutCnt;
  logic [FLAG_N-1:0] setV;
  logic              fifoFull, storeOk, doRead, armRdy, restart;

  assign fifoFull = fillCount == FULL_N;
  assign storeOk  = strb.frameDone && !strb.stopBad && !fifoFull && !flags[FLAG_BRK];
  assign doRead   = rdEn && fillCount != '0;
  assign newCount = fillCount + CNT_W'(storeOk) - CNT_W'(doRead);
  assign armRdy   = fillCount != '0 && fillCount < cfgTrig;
  assign restart  = strb.startSeen || storeOk || doRead;
  assign rdData   = mem[rdPtr];
  assign rdValid  = fillCount != '0;

  always_comb begin
    setV           = '0;
    setV[FLAG_FULL] = storeOk && newCount >= cfgTrig;
    setV[FLAG_ERR]  = strb.frameDone && (strb.stopBad || strb.parityBad);
    setV[FLAG_BRK]  = strb.frameDone && strb.allZero;
    setV[FLAG_RDY]  = sampleEn && armRdy && !restart && toutCnt == TOUT - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (storeOk) mem[wrPtr] <= wordIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      toutCnt   <= '0;
      flags     <= '0;
    end else begin
      if (storeOk) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRead)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      fillCount <= newCount;
      if (!armRdy || restart) toutCnt <= '0;
      else if (sampleEn && toutCnt != TOUT) toutCnt <= toutCnt + 1'b1;
      flags <= setV | (flags & ~flagClr);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL_N);

  // R7
  brk_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameDone && flags[FLAG_BRK] && !rdEn) |=> $stable(fillCount));

  // R5
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameDone && strb.stopBad && !rdEn) |=> $stable(fillCount));

  // R10
  rdy_when_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_RDY]) |-> $past(fillCount) != '0 && $past(fillCount) < $past(cfgTrig));

  // R4
  err_from_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_ERR]) |-> $past(strb.frameDone));
endmodule

// File: rtl/serialRxFifo.sv
module serialRxFifo
  import serRxPkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int FIFO_DEPTH     = 16,
  parameter int OVS            = 16,
  parameter int TIMEOUT_FRAMES = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sampleEn,
  input  logic                          rxdIn,
  input  logic                          cfgParityEn,
  input  logic                          cfgParityOdd,
  input  logic                          cfgTwoStop,
  input  logic [$clog2(FIFO_DEPTH):0]   cfgTrigLevel,
  input  logic [3:0]                    cfgIrqEn,
  input  logic [3:0]                    flagClr,
  input  logic                          rdEn,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdValid,
  output logic [$clog2(FIFO_DEPTH):0]   fillCount,
  output logic [3:0]                    flags,
  output logic                          irqOut
);
  localparam int TOUT_TICKS = TIMEOUT_FRAMES * OVS * (DATA_W + 4);

  rxStrb_t           strb;
  logic [DATA_W-1:0] word;

  rxCtrl #(.DATA_W(DATA_W), .OVS(OVS)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxdIn(rxdIn),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .strb(strb), .wordOut(word)
  );

  rxData #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .TOUT_TICKS(TOUT_TICKS)) uData (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .strb(strb), .wordIn(word),
    .cfgTrig(cfgTrigLevel), .flagClr(flagClr), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid), .fillCount(fillCount), .flags(flags)
  );

  assign irqOut = |(flags & cfgIrqEn);
endmodule

// File: tb/tb_serialRxFifo.sv
module tb_serialRxFifo;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, sampleEn, rxdIn, cfgParityEn, cfgParityOdd, cfgTwoStop, rdEn, rdValid, irqOut;
  logic [4:0] cfgTrigLevel, fillCount;
  logic [3:0] cfgIrqEn, flagClr, flags;
  logic [7:0] rdData;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  serialRxFifo dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxdIn(rxdIn),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .cfgTrigLevel(cfgTrigLevel), .cfgIrqEn(cfgIrqEn), .flagClr(flagClr), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid), .fillCount(fillCount), .flags(flags), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    if (!rstN) sampleEn <= 1'b0;
    else sampleEn <= ~sampleEn;
  end

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic holdBit(input logic b);
    rxdIn = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit badPar, input logic s1, input logic s2);
    holdBit(1'b1);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i]);
    if (cfgParityEn) holdBit((^d) ^ cfgParityOdd ^ badPar);
    holdBit(s1);
    if (cfgTwoStop) holdBit(s2);
    rxdIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop();
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic clearFlags(input logic [3:0] m);
    flagClr = m;
    @(negedge clk);
    flagClr = 4'h0;
  endtask

  task automatic setCfg(input bit pe, input bit po, input bit ts);
    cfgParityEn = pe; cfgParityOdd = po; cfgTwoStop = ts;
  endtask

  initial begin
    rstN = 1'b0; rxdIn = 1'b1; rdEn = 1'b0; flagClr = 4'h0; cfgIrqEn = 4'h0;
    cfgTrigLevel = 5'd16;
    setCfg(0, 0, 0);
    repeat (5) @(negedge clk);
    // R1 reset state
    chkEq("R1 flags", flags, 0);
    chkEq("R1 fill", fillCount, 0);
    chkEq("R1 rdValid", rdValid, 0);
    chkEq("R1 irq", irqOut, 0);
    rstN = 1'b1;
    repeat (40) @(negedge clk);

    // R3 sweep over framing configurations, R4 good parity gives no error
    for (int c = 0; c < 6; c++) begin
      setCfg(c >= 2, c >= 4, c % 2);
      for (int k = 0; k < 8; k++) begin
        logic [7:0] v;
        v = 8'((c * 61 + k * 37 + 5) & 255);
        sendFrame(v, 0, 1'b1, 1'b1);
        chkEq("R3 fill", fillCount, 1);
        chkEq("R3 data", rdData, v);
        chkEq("R4 no error", flags[1], 0);
        pop();
      end
    end

    // R2 glitch
    setCfg(0, 0, 0);
    clearFlags(4'hF);
    rxdIn = 1'b0;
    repeat (8) @(negedge clk);
    rxdIn = 1'b1;
    repeat (64) @(negedge clk);
    chkEq("R2 glitch fill", fillCount, 0);
    chkEq("R2 glitch flags", flags, 0);

    // R5 bad first stop, R6 next frame accepted
    sendFrame(8'h33, 0, 1'b0, 1'b1);
    chkEq("R5 stop err", flags[1], 1);
    chkEq("R5 dropped", fillCount, 0);
    chkEq("R5 not break", flags[2], 0);
    sendFrame(8'hC3, 0, 1'b1, 1'b1);
    chkEq("R6 fill", fillCount, 1);
    chkEq("R6 data", rdData, 8'hC3);
    pop();
    clearFlags(4'hF);

    // R5 second stop ignored
    setCfg(0, 0, 1);
    sendFrame(8'h96, 0, 1'b1, 1'b0);
    chkEq("R5 stop2 stored", fillCount, 1);
    chkEq("R5 stop2 data", rdData, 8'h96);
    chkEq("R5 stop2 no err", flags[1], 0);
    pop();

    // R4 parity mismatch: error set, word kept
    setCfg(1, 0, 0);
    sendFrame(8'h5B, 1, 1'b1, 1'b1);
    chkEq("R4 par err", flags[1], 1);
    chkEq("R4 par stored", fillCount, 1);
    chkEq("R4 par data", rdData, 8'h5B);
    pop();
    clearFlags(4'hF);
    setCfg(1, 1, 0);
    sendFrame(8'h5B, 1, 1'b1, 1'b1);
    chkEq("R4 odd par err", flags[1], 1);
    pop();
    clearFlags(4'hF);

    // R7 break then blocking
    setCfg(0, 0, 0);
    sendFrame(8'h00, 0, 1'b0, 1'b0);
    chkEq("R7 brk flag", flags[2], 1);
    chkEq("R7 brk err", flags[1], 1);
    chkEq("R7 brk fill", fillCount, 0);
    sendFrame(8'h5A, 0, 1'b1, 1'b1);
    chkEq("R7 blocked", fillCount, 0);
    // R12 interrupt mask
    cfgIrqEn = 4'b0100; @(negedge clk);
    chkEq("R12 brk irq", irqOut, 1);
    cfgIrqEn = 4'b1001; @(negedge clk);
    chkEq("R12 masked", irqOut, 0);
    cfgIrqEn = 4'h0;
    // R11 clear
    clearFlags(4'b0110);
    chkEq("R11 cleared", flags, 0);
    sendFrame(8'h5A, 0, 1'b1, 1'b1);
    chkEq("R7 after clear", fillCount, 1);
    chkEq("R7 after clear data", rdData, 8'h5A);
    pop();

    // R9 trigger level
    cfgTrigLevel = 5'd4;
    for (int i = 0; i < 3; i++) sendFrame(8'(8'h10 + i), 0, 1'b1, 1'b1);
    chkEq("R9 below trig", flags[0], 0);
    sendFrame(8'h13, 0, 1'b1, 1'b1);
    chkEq("R9 at trig", flags[0], 1);
    cfgIrqEn = 4'b0001; @(negedge clk);
    chkEq("R12 full irq", irqOut, 1);
    cfgIrqEn = 4'h0;
    clearFlags(4'b0001);
    chkEq("R11 full cleared", flags[0], 0);
    for (int i = 0; i < 4; i++) begin
      chkEq("R9 order", rdData, 8'h10 + i);
      pop();
    end

    // R10 data-ready timeout
    clearFlags(4'hF);
    sendFrame(8'h21, 0, 1'b1, 1'b1);
    repeat (1000) @(negedge clk);
    chkEq("R10 early", flags[3], 0);
    repeat (200) @(negedge clk);
    chkEq("R10 fired", flags[3], 1);
    cfgIrqEn = 4'b1000; @(negedge clk);
    chkEq("R12 rdy irq", irqOut, 1);
    cfgIrqEn = 4'h0;
    pop();
    clearFlags(4'hF);

    // R8 full queue, drop, empty read
    cfgTrigLevel = 5'd16;
    for (int i = 0; i < 17; i++) sendFrame(8'(8'h40 + i), 0, 1'b1, 1'b1);
    chkEq("R8 full count", fillCount, 16);
    chkEq("R9 full flag", flags[0], 1);
    chkEq("R8 head", rdData, 8'h40);
    for (int i = 0; i < 16; i++) begin
      if (i == 15) chkEq("R8 last kept", rdData, 8'h4F);
      pop();
    end
    chkEq("R8 drained", fillCount, 0);
    pop();
    chkEq("R8 empty read", fillCount, 0);
    chkEq("R8 empty valid", rdValid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule